// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block takes received frames from a byte stream and places them in host memory by way of a ring of 32-byte receive descriptors. For each frame it first reads three words of the current descriptor: the control word, the size halfwords and the buffer-1 address. If the descriptor belongs to the engine, the frame bytes go to buffer 1 as little-endian 32-bit writes. The engine then writes a status word back over the control word and moves its ring pointer to the next descriptor.

It raises single-cycle event pulses for a completed frame and for a missing buffer. It also keeps running counts of bytes, frames, broadcast frames and multicast frames. Memory is reached through a plain word port: every request is accepted at once, and read data comes back one cycle after the read request. Filtering on destination address and checking the frame check sequence are left to other blocks.

Top module: `rxwb_engine`

## Requirements
- R1: While `rx_en` is low and the engine is idle, `s_ready` stays low and no memory request is issued. A pending frame waits until `rx_en` rises.
- R2: A frame whose `frame_len` is below 12 is consumed with no memory access of any kind. It pulses `ev_rx_int` and `ev_norm_sum` once, and it leaves the counters and `cur_ptr` unchanged.
- R3: If bit 31 of the descriptor word at `cur_ptr` is 0, the frame is consumed with no memory write. It pulses `ev_buf_unavail` and `ev_abn_sum` once, and it leaves `cur_ptr` and the counters unchanged.
- R4: Frame byte k is written to address A + k, where A is the descriptor word at `cur_ptr`+8. Bytes are packed little-endian into 32-bit writes, with `mem_be` bit i enabling byte lane i. A final partial word enables only its low lanes, and no byte past the frame is written.
- R5: After the data, the word at `cur_ptr` is overwritten with `{frame_len + 4, 16'h0300}`. The length sits in bits 31:16, bits 9 and 8 are set, and bit 31 (ownership) ends clear for any frame shorter than 32764 bytes.
- R6: After the write-back, `cur_ptr` takes the value `ring_base` if bit 15 of the word at `cur_ptr`+4 is set, and otherwise advances by 32. A `ring_load` pulse copies `ring_base` into `cur_ptr`.
- R7: Each written-back frame adds `frame_len` + 4 to `stat_bytes`, adds 1 to `stat_frames`, and pulses `ev_rx_int` and `ev_norm_sum` once, in the cycle after the write-back.
- R8: A written-back frame whose first six bytes are all 8'hFF adds 1 to `stat_bcast`. One whose first byte has bit 0 set and is not broadcast adds 1 to `stat_mcast`.
- R9: `s_ready` is low in every cycle in which the engine reads the descriptor or writes back its status.
- R10: After reset, `cur_ptr` and all four counters are 0, `s_ready` is low and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Byte address of the first descriptor of the ring |
| ring_load | input | 1 | Pulse: copy ring_base into the current pointer |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of the frame |
| frame_len | input | 16 | Frame length in bytes, held for the whole frame |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| ev_rx_int | output | 1 | Receive-complete event pulse |
| ev_norm_sum | output | 1 | Normal-summary event pulse |
| ev_buf_unavail | output | 1 | Buffer-unavailable event pulse |
| ev_abn_sum | output | 1 | Abnormal-summary event pulse |
| cur_ptr | output | 32 | Current descriptor byte address |
| stat_bytes | output | 32 | Received byte count including 4 CRC bytes per frame |
| stat_frames | output | 32 | Received frame count |
| stat_bcast | output | 32 | Broadcast frame count |
| stat_mcast | output | 32 | Multicast frame count |

## Verification
The hardest case to reach is the interplay of the ring wrap with descriptors the engine does not own. It needs the pointer to sit on the one descriptor whose size halfword carries the wrap bit, while earlier frames have skipped past or stalled on unowned entries. The stimulus mixes random lengths, random destination classes and a random one-in-eight chance of an unowned descriptor or a runt over many frames on a four-entry ring, so the pointer keeps reaching the wrap entry in varied states. Directed frames of 12, 13 and 15 bytes cover the partial last word, and a held frame with receive disabled covers the refusal case.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int unsigned RXWB_AW         = 32;
  localparam int unsigned RXWB_LEN_W      = 16;
  localparam int unsigned RXWB_DESC_BYTES = 32;
  localparam int unsigned RXWB_CRC_BYTES  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTL, ST_RD_SIZE, ST_RD_BUF, ST_CHECK, ST_DATA, ST_DROP, ST_WB
  } rx_state_t;

  typedef enum logic [0:0] { DROP_RUNT, DROP_UNOWNED } drop_kind_t;

  // length as stored in the write-back word and in the byte counter
  function automatic logic [RXWB_LEN_W-1:0] wire_octets(input logic [RXWB_LEN_W-1:0] len);
    return len + RXWB_LEN_W'(RXWB_CRC_BYTES);
  endfunction

  function automatic logic [31:0] status_word(input logic [RXWB_LEN_W-1:0] len);
    return {wire_octets(len), 16'h0300};
  endfunction

  function automatic logic [RXWB_AW-1:0] advance_ptr(input logic [RXWB_AW-1:0] cur,
                                                     input logic [RXWB_AW-1:0] base,
                                                     input logic wrap);
    return wrap ? base : cur + RXWB_AW'(RXWB_DESC_BYTES);
  endfunction
endpackage

// File: rtl/rxwb_packer.sv
module rxwb_packer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat,
  input  logic [7:0]        data,
  input  logic              last,
  output logic              wr_fire,
  output logic [DATA_W-1:0] word,
  output logic [DATA_W/8-1:0] be
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] acc;

  always_comb begin
    word = acc;
    word[lane*8 +: 8] = data;
    for (int i = 0; i < LANES; i++) be[i] = (i <= int'(lane));
  end

  assign wr_fire = beat && ((lane == LANE_W'(LANES - 1)) || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane <= '0;
      acc  <= '0;
    end else if (clear) begin
      lane <= '0;
      acc  <= '0;
    end else if (beat) begin
      if (wr_fire) begin
        lane <= '0;
        acc  <= '0;
      end else begin
        lane <= lane + LANE_W'(1);
        acc  <= word;
      end
    end
  end
endmodule

// File: rtl/rxwb_classify.sv
module rxwb_classify #(
  parameter int unsigned DEST_BYTES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       beat,
  input  logic [7:0] data,
  output logic       is_bcast,
  output logic       is_mcast
);
  localparam int unsigned IDX_W = $clog2(DEST_BYTES + 1);

  logic [IDX_W-1:0] idx;
  logic             all_ones;
  logic             group_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      all_ones  <= 1'b1;
      group_bit <= 1'b0;
    end else if (clear) begin
      idx       <= '0;
      all_ones  <= 1'b1;
      group_bit <= 1'b0;
    end else if (beat && (idx < IDX_W'(DEST_BYTES))) begin
      idx <= idx + IDX_W'(1);
      if (data != 8'hFF) all_ones <= 1'b0;
      if (idx == '0) group_bit <= data[0];
    end
  end

  assign is_bcast = all_ones;
  assign is_mcast = group_bit && !all_ones;
endmodule

// File: rtl/rxwb_stats.sv
module rxwb_stats #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic [LEN_W-1:0] octets,
  input  logic             bcast,
  input  logic             mcast,
  output logic [CNT_W-1:0] n_bytes,
  output logic [CNT_W-1:0] n_frames,
  output logic [CNT_W-1:0] n_bcast,
  output logic [CNT_W-1:0] n_mcast
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_bytes  <= '0;
      n_frames <= '0;
      n_bcast  <= '0;
      n_mcast  <= '0;
    end else if (bump) begin
      n_bytes  <= n_bytes + CNT_W'(octets);
      n_frames <= n_frames + CNT_W'(1);
      if (bcast) n_bcast <= n_bcast + CNT_W'(1);
      if (mcast) n_mcast <= n_mcast + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
  import rxwb_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MIN_LEN = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_en,
  input  logic [RXWB_AW-1:0]    ring_base,
  input  logic                  ring_load,
  input  logic                  s_valid,
  input  logic [7:0]            s_data,
  input  logic                  s_last,
  input  logic [RXWB_LEN_W-1:0] frame_len,
  output logic                  s_ready,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [RXWB_AW-1:0]    mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_be,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  ev_rx_int,
  output logic                  ev_norm_sum,
  output logic                  ev_buf_unavail,
  output logic                  ev_abn_sum,
  output logic [RXWB_AW-1:0]    cur_ptr,
  output logic [CNT_W-1:0]      stat_bytes,
  output logic [CNT_W-1:0]      stat_frames,
  output logic [CNT_W-1:0]      stat_bcast,
  output logic [CNT_W-1:0]      stat_mcast
);
  localparam int unsigned BE_W = DATA_W / 8;
  localparam logic [RXWB_AW-1:0] WORD_STEP = RXWB_AW'(BE_W);
  localparam logic [RXWB_AW-1:0] OFS_SIZE  = RXWB_AW'(4);
  localparam logic [RXWB_AW-1:0] OFS_BUF   = RXWB_AW'(8);

  rx_state_t             state;
  drop_kind_t            drop_kind;
  logic [RXWB_LEN_W-1:0] len_q;
  logic                  own_q;
  logic                  wrap_q;
  logic [RXWB_AW-1:0]    buf_ptr;

  // named internal events, also observed by the checker
  logic in_desc_phase;
  logic frame_start;
  logic beat;
  logic wb_done;
  logic pk_fire;
  logic [DATA_W-1:0] pk_word;
  logic [BE_W-1:0]   pk_be;
  logic cl_bcast, cl_mcast;

  assign s_ready       = (state == ST_DATA) || (state == ST_DROP);
  assign beat          = s_valid && s_ready;
  assign frame_start   = (state == ST_IDLE) && s_valid && rx_en;
  assign wb_done       = (state == ST_WB);
  assign in_desc_phase = (state == ST_RD_CTL) || (state == ST_RD_SIZE) ||
                         (state == ST_RD_BUF) || (state == ST_CHECK) || wb_done;

  rxwb_packer #(.DATA_W(DATA_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_CHECK),
    .beat(beat && (state == ST_DATA)), .data(s_data), .last(s_last),
    .wr_fire(pk_fire), .word(pk_word), .be(pk_be)
  );

  rxwb_classify #(.DEST_BYTES(6)) classify_i (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_CHECK),
    .beat(beat && (state == ST_DATA)), .data(s_data),
    .is_bcast(cl_bcast), .is_mcast(cl_mcast)
  );

  rxwb_stats #(.CNT_W(CNT_W), .LEN_W(RXWB_LEN_W)) stats_i (
    .clk(clk), .rst_n(rst_n), .bump(wb_done), .octets(wire_octets(len_q)),
    .bcast(cl_bcast), .mcast(cl_mcast),
    .n_bytes(stat_bytes), .n_frames(stat_frames),
    .n_bcast(stat_bcast), .n_mcast(stat_mcast)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (state)
      ST_RD_CTL:  mem_req = 1'b1;
      ST_RD_SIZE: begin mem_req = 1'b1; mem_addr = cur_ptr + OFS_SIZE; end
      ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_ptr + OFS_BUF;  end
      ST_DATA: begin
        mem_req   = pk_fire;
        mem_we    = pk_fire;
        mem_addr  = buf_ptr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = DATA_W'(status_word(len_q));
        mem_be    = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      drop_kind      <= DROP_RUNT;
      len_q          <= '0;
      own_q          <= 1'b0;
      wrap_q         <= 1'b0;
      buf_ptr        <= '0;
      cur_ptr        <= '0;
      ev_rx_int      <= 1'b0;
      ev_norm_sum    <= 1'b0;
      ev_buf_unavail <= 1'b0;
      ev_abn_sum     <= 1'b0;
    end else begin
      ev_rx_int      <= 1'b0;
      ev_norm_sum    <= 1'b0;
      ev_buf_unavail <= 1'b0;
      ev_abn_sum     <= 1'b0;
      unique case (state)
        ST_IDLE: if (frame_start) begin
          len_q <= frame_len;
          if (frame_len < RXWB_LEN_W'(MIN_LEN)) begin
            drop_kind <= DROP_RUNT;
            state     <= ST_DROP;
          end else begin
            state <= ST_RD_CTL;
          end
        end
        ST_RD_CTL:  state <= ST_RD_SIZE;
        ST_RD_SIZE: begin own_q  <= mem_rdata[31]; state <= ST_RD_BUF; end
        ST_RD_BUF:  begin wrap_q <= mem_rdata[15]; state <= ST_CHECK;  end
        ST_CHECK: begin
          buf_ptr <= RXWB_AW'(mem_rdata);
          if (own_q) begin
            state <= ST_DATA;
          end else begin
            drop_kind <= DROP_UNOWNED;
            state     <= ST_DROP;
          end
        end
        ST_DATA: begin
          if (pk_fire) buf_ptr <= buf_ptr + WORD_STEP;
          if (beat && s_last) state <= ST_WB;
        end
        ST_DROP: if (beat && s_last) begin
          if (drop_kind == DROP_RUNT) begin
            ev_rx_int   <= 1'b1;
            ev_norm_sum <= 1'b1;
          end else begin
            ev_buf_unavail <= 1'b1;
            ev_abn_sum     <= 1'b1;
          end
          state <= ST_IDLE;
        end
        ST_WB: begin
          ev_rx_int   <= 1'b1;
          ev_norm_sum <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (ring_load)    cur_ptr <= ring_base;
      else if (wb_done) cur_ptr <= advance_ptr(cur_ptr, ring_base, wrap_q);
    end
  end
endmodule

// File: rtl/rxwb_checker.sv
module rxwb_checker
  import rxwb_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned BE_W    = 4,
  parameter int unsigned MIN_LEN = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_en,
  input logic               s_ready,
  input logic               ring_load,
  input logic [RXWB_AW-1:0] ring_base,
  input logic               mem_req,
  input logic               mem_we,
  input logic [BE_W-1:0]    mem_be,
  input logic               ev_rx_int,
  input logic               ev_norm_sum,
  input logic               ev_buf_unavail,
  input logic               ev_abn_sum,
  input logic [RXWB_AW-1:0] cur_ptr,
  input logic [CNT_W-1:0]   stat_bytes,
  input logic [CNT_W-1:0]   stat_frames,
  input logic               in_desc_phase,
  input logic               frame_start
);
  // R1: idle and disabled means no stream acceptance on the next cycle
  p_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !s_ready && !in_desc_phase && !frame_start) |=> !s_ready);

  // R9: no stream acceptance during descriptor access
  p_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_desc_phase |-> !s_ready);

  // R3: buffer-unavailable comes with the abnormal summary and no frame count
  p_unavail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_unavail |-> (ev_abn_sum && !ev_rx_int && $stable(stat_frames)));

  // R7: frame count steps by one together with the receive event
  p_frames_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_frames) |-> (ev_rx_int && ev_norm_sum &&
                               stat_frames == $past(stat_frames) + CNT_W'(1)));

  // R7: byte count grows by at least the minimum frame plus CRC
  p_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_frames) |->
      (stat_bytes - $past(stat_bytes) >= CNT_W'(MIN_LEN + RXWB_CRC_BYTES)));

  // R6: pointer moves only by one descriptor or back to the base
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_ptr) && !$past(ring_load)) |->
      (cur_ptr == $past(cur_ptr) + RXWB_AW'(RXWB_DESC_BYTES) ||
       cur_ptr == $past(ring_base)));

  // R4: write lane enables are contiguous from lane 0
  p_be_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be[0] && $onehot0(mem_be + BE_W'(1))));
endmodule

bind rxwb_engine rxwb_checker #(
  .CNT_W(CNT_W), .BE_W(DATA_W / 8), .MIN_LEN(MIN_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .s_ready(s_ready),
  .ring_load(ring_load), .ring_base(ring_base),
  .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
  .ev_rx_int(ev_rx_int), .ev_norm_sum(ev_norm_sum),
  .ev_buf_unavail(ev_buf_unavail), .ev_abn_sum(ev_abn_sum),
  .cur_ptr(cur_ptr), .stat_bytes(stat_bytes), .stat_frames(stat_frames),
  .in_desc_phase(in_desc_phase), .frame_start(frame_start)
);

// File: tb/rxwb_engine_tb_top.sv
`timescale 1ns/1ps
module rxwb_engine_tb_top;
  localparam logic [31:0] BASE  = 32'h100;
  localparam int          NDESC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [31:0] ring_base = BASE;
  logic        ring_load = 1'b0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic [15:0] frame_len = '0;
  logic        s_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        ev_rx_int, ev_norm_sum, ev_buf_unavail, ev_abn_sum;
  logic [31:0] cur_ptr, stat_bytes, stat_frames, stat_bcast, stat_mcast;

  always #10 clk = ~clk;

  rxwb_engine dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base), .ring_load(ring_load),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .frame_len(frame_len),
    .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .ev_rx_int(ev_rx_int), .ev_norm_sum(ev_norm_sum), .ev_buf_unavail(ev_buf_unavail),
    .ev_abn_sum(ev_abn_sum), .cur_ptr(cur_ptr), .stat_bytes(stat_bytes),
    .stat_frames(stat_frames), .stat_bcast(stat_bcast), .stat_mcast(stat_mcast)
  );

  // word memory, one-cycle read latency
  logic [31:0] mem [0:1023];
  int n_wr = 0, n_rd = 0, n_ri = 0, n_nis = 0, n_ru = 0, n_ais = 0, n_ready_rd = 0;
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[11:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
        n_wr++;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        n_rd++;
      end
    end
    if (rst_n) begin
      if (ev_rx_int) n_ri++;
      if (ev_norm_sum) n_nis++;
      if (ev_buf_unavail) n_ru++;
      if (ev_abn_sum) n_ais++;
    end
  end
  always @(negedge clk) if (s_ready && mem_req && !mem_we) n_ready_rd++;

  int nchecks = 0, errors = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; nchecks++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end

  // bench model
  logic [31:0] exp_ptr = 0, exp_bytes = 0, exp_frames = 0, exp_bc = 0, exp_mc = 0;
  int exp_ri = 0, exp_ru = 0;
  logic [7:0] fb [0:255];

  function automatic logic [31:0] exp_status(input int len);
    logic [15:0] l = 16'(len + 4);
    return (32'(l) << 16) | 32'h0000_0300;
  endfunction

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      s_valid = 1'b1; s_data = fb[i]; s_last = (i == len - 1); frame_len = 16'(len);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  // kind: 0 unicast, 1 broadcast, 2 multicast
  task automatic run_frame(input int len, input int kind, input bit own);
    int slot = int'((exp_ptr - BASE) / 32);
    logic [31:0] d = exp_ptr;
    logic [31:0] bufa = 32'h400 + 32'(slot) * 32'h100;
    int wr0 = n_wr, rd0 = n_rd;
    int nw;
    logic [31:0] ew;
    for (int i = 0; i < 64; i++) mem[bufa[11:2] + 10'(i)] = 32'hA5A5_A5A5;
    mem[d[11:2]]      = own ? 32'h8000_0000 : 32'h0;
    mem[d[11:2] + 10'd1] = (slot == NDESC - 1) ? 32'h0000_8800 : 32'h0000_0800;
    mem[d[11:2] + 10'd2] = bufa;
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    if (len >= 6) begin
      if (kind == 1) for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
      else if (kind == 2) begin fb[0] = fb[0] | 8'h01; fb[1] = 8'h00; end
      else fb[0] = fb[0] & 8'hFE;
    end
    send(len);
    repeat (4) @(negedge clk);
    if (len < 12) begin
      exp_ri++;
      chk("R2 runt no memory access", 64'(n_wr - wr0 + n_rd - rd0), 0);
      chk("R2 runt receive event", 64'(n_ri), 64'(exp_ri));
      chk("R2 runt summary event", 64'(n_nis), 64'(exp_ri));
      chk("R2 runt frames unchanged", 64'(stat_frames), 64'(exp_frames));
      chk("R2 runt pointer unchanged", 64'(cur_ptr), 64'(exp_ptr));
    end else if (!own) begin
      exp_ru++;
      chk("R3 unowned no write", 64'(n_wr - wr0), 0);
      chk("R3 unavailable event", 64'(n_ru), 64'(exp_ru));
      chk("R3 abnormal summary", 64'(n_ais), 64'(exp_ru));
      chk("R3 descriptor untouched", 64'(mem[d[11:2]]), 0);
      chk("R3 pointer unchanged", 64'(cur_ptr), 64'(exp_ptr));
      chk("R3 frames unchanged", 64'(stat_frames), 64'(exp_frames));
    end else begin
      nw = (len + 3) / 4;
      for (int w = 0; w <= nw; w++) begin
        ew = 32'hA5A5_A5A5;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < len) ew[b*8 +: 8] = fb[w*4 + b];
        chk("R4 buffer word", 64'(mem[bufa[11:2] + 10'(w)]), 64'(ew));
      end
      chk("R5 status word", 64'(mem[d[11:2]]), 64'(exp_status(len)));
      exp_ptr = (slot == NDESC - 1) ? BASE : exp_ptr + 32;
      exp_bytes += 32'(len + 4);
      exp_frames++;
      exp_ri++;
      if (kind == 1) exp_bc++;
      if (kind == 2) exp_mc++;
      chk("R6 pointer", 64'(cur_ptr), 64'(exp_ptr));
      chk("R7 bytes", 64'(stat_bytes), 64'(exp_bytes));
      chk("R7 frames", 64'(stat_frames), 64'(exp_frames));
      chk("R7 receive event", 64'(n_ri), 64'(exp_ri));
      chk("R8 broadcast", 64'(stat_bcast), 64'(exp_bc));
      chk("R8 multicast", 64'(stat_mcast), 64'(exp_mc));
    end
  endtask

  initial begin
    int seed = 32'h5eed;
    int ready_seen = 0;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset pointer", 64'(cur_ptr), 0);
    chk("R10 reset frames", 64'(stat_frames), 0);
    chk("R10 reset bytes", 64'(stat_bytes), 0);
    chk("R10 reset ready", 64'(s_ready), 0);
    chk("R10 reset events", 64'(n_ri + n_ru), 0);

    ring_load = 1'b1; @(negedge clk); ring_load = 1'b0;
    exp_ptr = BASE;
    chk("R6 ring load", 64'(cur_ptr), 64'(BASE));

    // R1: held frame while disabled
    s_valid = 1'b1; s_data = 8'h11; frame_len = 16'd20;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (s_ready) ready_seen++;
    end
    s_valid = 1'b0;
    chk("R1 ready low while disabled", 64'(ready_seen), 0);
    chk("R1 no memory access while disabled", 64'(n_rd + n_wr), 0);

    rx_en = 1'b1;
    @(negedge clk);
    run_frame(12, 1, 1'b1);
    run_frame(13, 2, 1'b1);
    run_frame(15, 0, 1'b1);
    run_frame(11, 0, 1'b1);
    run_frame(40, 0, 1'b0);
    run_frame(33, 1, 1'b1);
    for (int k = 0; k < 40; k++) begin
      int r = int'($urandom % 8);
      int len = (r == 0) ? 1 + int'($urandom % 11) : 12 + int'($urandom % 100);
      run_frame(len, int'($urandom % 3), r != 1);
    end
    chk("R9 ready low during descriptor reads", 64'(n_ready_rd), 0);
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end
endmodule